// File: doc/BRIEF.md
# Write Permission Guard with Status Register

This block holds the status byte of a serial nonvolatile memory and decides, cycle by cycle, whether an array write or a status write may go ahead. The byte combines a write-enable latch, a copy of the write-cycle busy flag, a two-bit fence that protects the top quarter, the top half or all of the array, and an enable bit that lets an external protect pin lock the status register.

The frame decoder that sits next to this block sends it single-cycle events. These are "latch set" and "latch clear" when the matching short frames finish correctly, "status commit" with new data, and "array commit" with the page index of the frame. The guard drives combinational allow flags for the current page and the current pin level. It only acts on a commit when the matching allow flag is high in that same cycle.

Non-volatile retention is modelled by ordinary registers. The fence and pin-enable bits reset to parameter values.

Top module: `sr_guard`

## Requirements
- R1: The status byte `status_o` puts the pin-enable bit at bit 7 and reads 0 at bits 6..4. Bits 3..2 hold the fence code, bit 1 the write-enable latch, and bit 0 the value of `busy_i` registered one clock earlier. After reset it reads {RST_PEN,000,RST_BP,0,0}.
- R2: `wel_set_i` sets the latch and `wel_clr_i` clears it, whatever the fence, pin-enable and pin state. If both arrive in the same cycle, the clear wins.
- R3: The fence code works on the page index (the top PG_W address bits). 00 protects nothing. 01 protects the pages whose two top index bits are 11 (the upper quarter), 10 protects the pages whose top index bit is 1 (the upper half), and 11 protects every page.
- R4: `arr_ok_o` is high exactly when the latch is set, status bit 0 is 0, and the page on `page_i` is not fenced.
- R5: `sr_ok_o` is high exactly when the latch is set, status bit 0 is 0, and status bit 7 is 0 or `prot_pin_i` is 1. The pin counts only in the cycle of a status commit; changing it later leaves the register unchanged.
- R6: An allowed status commit loads bit 7 and bits 3..2 from `sr_data_i` and clears the latch. Data bits 6..4, 1 and 0 are ignored.
- R7: A status commit that is not allowed changes no bit of the status byte.
- R8: An allowed array commit clears the latch. A denied one leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wel_set_i | input | 1 | Latch-set frame completed |
| wel_clr_i | input | 1 | Latch-clear frame completed |
| busy_i | input | 1 | Internal write cycle running |
| prot_pin_i | input | 1 | Protect pin level (low = lock request) |
| page_i | input | ADDR_W-PAGE_LOG2 | Page index of the pending array frame |
| arr_commit_i | input | 1 | Array write frame ended validly |
| sr_commit_i | input | 1 | Status write frame ended validly |
| sr_data_i | input | 8 | New status data |
| status_o | output | 8 | Status byte for reads |
| arr_ok_o | output | 1 | Array write allowed for `page_i` |
| sr_ok_o | output | 1 | Status write allowed |

## Verification
The bench uses the default build: a 10-bit address with 16-byte pages, which gives 64 pages. That is small enough to sweep every page index under every fence code, every pin-enable value, both latch states and both pin levels, and to compare both allow flags against fence limits the bench computes as fractions of the page count. Directed sequences then cover the commit outcomes, a later pin change, and the busy gate.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    typedef struct packed {
        logic       pen;
        logic [1:0] bp;
        logic       wel;
        logic       busy;
    } sreg_t;

    localparam int SR_PEN_BIT  = 7;
    localparam int SR_BP_HI    = 3;
    localparam int SR_BP_LO    = 2;

endpackage

// File: rtl/sr_fence.sv
module sr_fence #(
    parameter int PG_W = 6
) (
    input  logic [1:0]      bp,
    input  logic [PG_W-1:0] page,
    output logic            hit
);
    always_comb begin
        case (bp)
            2'b00:   hit = 1'b0;
            2'b01:   hit = &page[PG_W-1:PG_W-2];
            2'b10:   hit = page[PG_W-1];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_perm.sv
module sr_perm (
    input  logic wel,
    input  logic busy,
    input  logic pen,
    input  logic pin,
    input  logic fence_hit,
    output logic arr_ok,
    output logic sr_ok
);
    logic pin_lock;

    always_comb begin
        pin_lock = pen & ~pin;
        arr_ok   = wel & ~busy & ~fence_hit;
        sr_ok    = wel & ~busy & ~pin_lock;
    end
endmodule

// File: rtl/sr_state.sv
module sr_state
    import sr_guard_pkg::*;
#(
    parameter logic [1:0] RST_BP  = 2'b00,
    parameter logic       RST_PEN = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_ev,
    input  logic       clr_ev,
    input  logic       sr_go,
    input  logic [7:0] sr_data,
    input  logic       arr_go,
    input  logic       busy_in,
    output sreg_t      q
);
    sreg_t d, q_q;

    always_comb begin
        d      = q_q;
        d.busy = busy_in;
        if (sr_go) begin
            d.pen = sr_data[SR_PEN_BIT];
            d.bp  = sr_data[SR_BP_HI:SR_BP_LO];
        end
        if (set_ev)
            d.wel = 1'b1;
        if (clr_ev || sr_go || arr_go)
            d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q.pen  <= RST_PEN;
            q_q.bp   <= RST_BP;
            q_q.wel  <= 1'b0;
            q_q.busy <= 1'b0;
        end else begin
            q_q <= d;
        end
    end

    assign q = q_q;

    // R2: a set with no clearing event leaves the latch high
    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev && !clr_ev && !sr_go && !arr_go) |=> q_q.wel);

    // R2: a clear event always wins
    a_r2_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ev |=> !q_q.wel);

    // R1: busy bit tracks the input one clock later
    a_r1_busy_lag: assert property (@(posedge clk) disable iff (!rst_n)
        busy_in |=> q_q.busy);
endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int         ADDR_W    = 10,
    parameter int         PAGE_LOG2 = 4,
    parameter logic [1:0] RST_BP    = 2'b00,
    parameter logic       RST_PEN   = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wel_set_i,
    input  logic                        wel_clr_i,
    input  logic                        busy_i,
    input  logic                        prot_pin_i,
    input  logic [ADDR_W-PAGE_LOG2-1:0] page_i,
    input  logic                        arr_commit_i,
    input  logic                        sr_commit_i,
    input  logic [7:0]                  sr_data_i,
    output logic [7:0]                  status_o,
    output logic                        arr_ok_o,
    output logic                        sr_ok_o
);
    localparam int PG_W = ADDR_W - PAGE_LOG2;

    sreg_t st;
    logic  fence_hit;
    logic  sr_go, arr_go;

    sr_fence #(.PG_W(PG_W)) u_fence (
        .bp   (st.bp),
        .page (page_i),
        .hit  (fence_hit)
    );

    sr_perm u_perm (
        .wel       (st.wel),
        .busy      (st.busy),
        .pen       (st.pen),
        .pin       (prot_pin_i),
        .fence_hit (fence_hit),
        .arr_ok    (arr_ok_o),
        .sr_ok     (sr_ok_o)
    );

    always_comb begin
        sr_go  = sr_commit_i & sr_ok_o;
        arr_go = arr_commit_i & arr_ok_o;
    end

    sr_state #(.RST_BP(RST_BP), .RST_PEN(RST_PEN)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (wel_set_i),
        .clr_ev  (wel_clr_i),
        .sr_go   (sr_go),
        .sr_data (sr_data_i),
        .arr_go  (arr_go),
        .busy_in (busy_i),
        .q       (st)
    );

    always_comb begin
        status_o = {st.pen, 3'b000, st.bp, st.wel, st.busy};
    end

    // R4: fenced page never allowed
    a_r4_fence_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fence_hit |-> !arr_ok_o);

    // R4/R5: no latch, no write
    a_r5_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[1] |-> (!arr_ok_o && !sr_ok_o));

    // R5: enabled pin held low locks the status register
    a_r5_pin_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !prot_pin_i) |-> !sr_ok_o);

    // R6: an accepted status commit clears the latch
    a_r6_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_commit_i && sr_ok_o) |=> !status_o[1]);

    // R7: a refused status commit keeps the configuration bits
    a_r7_denied_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_commit_i && !sr_ok_o) |=> $stable(status_o[7:2]));

    // R8: an accepted array commit clears the latch
    a_r8_arr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_commit_i && arr_ok_o) |=> !status_o[1]);
endmodule

// File: tb/sim_sr_guard.sv
module sim_sr_guard;
    localparam int ADDR_W    = 10;
    localparam int PAGE_LOG2 = 4;
    localparam int PG_W      = ADDR_W - PAGE_LOG2;
    localparam int NPG       = 1 << PG_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wel_set_i = 0, wel_clr_i = 0, busy_i = 0, prot_pin_i = 1;
    logic [PG_W-1:0] page_i = '0;
    logic            arr_commit_i = 0, sr_commit_i = 0;
    logic [7:0]      sr_data_i = '0;
    logic [7:0]      status_o;
    logic            arr_ok_o, sr_ok_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    sr_guard #(.ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i), .busy_i(busy_i),
        .prot_pin_i(prot_pin_i), .page_i(page_i),
        .arr_commit_i(arr_commit_i), .sr_commit_i(sr_commit_i),
        .sr_data_i(sr_data_i),
        .status_o(status_o), .arr_ok_o(arr_ok_o), .sr_ok_o(sr_ok_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic pulse_set();
        @(negedge clk); wel_set_i = 1;
        @(negedge clk); wel_set_i = 0; #1;
    endtask

    task automatic pulse_clr();
        @(negedge clk); wel_clr_i = 1;
        @(negedge clk); wel_clr_i = 0; #1;
    endtask

    task automatic sr_write(input logic [7:0] dat);
        @(negedge clk); sr_commit_i = 1; sr_data_i = dat;
        @(negedge clk); sr_commit_i = 0; #1;
    endtask

    task automatic arr_write(input int pg);
        @(negedge clk); arr_commit_i = 1; page_i = PG_W'(pg);
        @(negedge clk); arr_commit_i = 0; #1;
    endtask

    function automatic bit exp_fence(input int bp, input int pg);
        int lim;
        case (bp)
            0: lim = NPG;
            1: lim = NPG - NPG / 4;
            2: lim = NPG - NPG / 2;
            default: lim = 0;
        endcase
        return pg >= lim;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 reset status", status_o, 8'h00);
        chk("R4 reset arr_ok", arr_ok_o, 0);
        chk("R5 reset sr_ok", sr_ok_o, 0);
        rst_n = 1;

        // R2 latch set / clear / clash
        pulse_set();
        chk("R2 set latch", status_o, 8'h02);
        pulse_clr();
        chk("R2 clear latch", status_o, 8'h00);
        pulse_set();
        @(negedge clk); wel_set_i = 1; wel_clr_i = 1;
        @(negedge clk); wel_set_i = 0; wel_clr_i = 0; #1;
        chk("R2 clear wins", status_o, 8'h00);

        // R3 R4 R5 R6 sweep
        for (int bp = 0; bp < 4; bp++) begin
            for (int pen = 0; pen < 2; pen++) begin
                prot_pin_i = 1;
                pulse_set();
                sr_write({pen[0], 3'b111, bp[1:0], 2'b11});
                chk("R6 status load", status_o, {pen[0], 3'b000, bp[1:0], 2'b00});
                for (int wel = 0; wel < 2; wel++) begin
                    if (wel == 1) pulse_set();
                    for (int pin = 0; pin < 2; pin++) begin
                        prot_pin_i = pin[0];
                        for (int pg = 0; pg < NPG; pg++) begin
                            page_i = PG_W'(pg);
                            #1;
                            chk("R3 R4 arr_ok", arr_ok_o,
                                (wel == 1) && !exp_fence(bp, pg));
                            chk("R5 sr_ok", sr_ok_o,
                                (wel == 1) && !(pen == 1 && pin == 0));
                        end
                    end
                    if (wel == 1) pulse_clr();
                end
            end
        end

        // R2 latch set regardless of lock state
        prot_pin_i = 1;
        pulse_set();
        sr_write(8'h84);
        prot_pin_i = 0;
        pulse_set();
        chk("R2 set under lock", status_o, 8'h86);

        // R7 denied status commit
        sr_write(8'h08);
        chk("R7 denied keeps status", status_o, 8'h86);

        // R5 pin only matters at commit
        prot_pin_i = 1;
        sr_write(8'h88);
        chk("R6 allowed commit", status_o, 8'h88);
        prot_pin_i = 0;
        @(negedge clk); #1;
        chk("R5 later pin change", status_o, 8'h88);

        // R8 array commits
        pulse_set();
        arr_write(NPG / 2 + 8);
        chk("R8 denied keeps latch", status_o, 8'h8A);
        arr_write(5);
        chk("R8 allowed clears latch", status_o, 8'h88);

        // R1 R4 R5 busy gating
        pulse_set();
        @(negedge clk); busy_i = 1; page_i = PG_W'(5); prot_pin_i = 1;
        @(negedge clk); #1;
        chk("R1 busy bit", status_o, 8'h8B);
        chk("R4 busy blocks array", arr_ok_o, 0);
        chk("R5 busy blocks status", sr_ok_o, 0);
        busy_i = 0;
        @(negedge clk); #1;
        chk("R1 busy drops", status_o, 8'h8A);
        chk("R4 idle allows array", arr_ok_o, 1);

        done = 1;
        finish_run();
    end
endmodule